// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block sequences bulk transfers between a working memory and its nonvolatile shadow copy. A store moves the working contents into the shadow in two phases: the old shadow data is erased, then the shadow is programmed. A recall also runs in two phases: the working memory is cleared, then the shadow data is copied into it. The shadow is never altered by a recall. The array itself and the detection of the command sequences sit outside this block. This block only issues a phase code to the array and flags the bus as unavailable while a transfer runs.

A supply-good flag controls two protection rules. Its first rising edge after reset starts an automatic recall, which uses its own restore duration. A low supply refuses a new store and stops a running store. A running recall is never stopped by a low supply. Once a transfer has started, it runs to completion on its own timers. Every request that arrives during a transfer is discarded. All phase lengths are cycle-count parameters. Each total is split into a first phase of floor(N/2) cycles and a second phase with the remaining cycles.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: After reset, `busy` and `bus_off` are 0, `array_op` is 0 (idle) and `store_abort` is 0.
- R2: A store accepted at a clock edge shows `array_op` = 1 (erase) for STORE_CYC/2 cycles, starting at that edge. It then shows 2 (program) for the remaining cycles, and then 0.
- R3: A recall request accepted at an edge shows `array_op` = 3 (clear) for RECALL_CYC/2 cycles. It then shows 4 (copy) for the remaining cycles, and then 0.
- R4: `busy` and `bus_off` are both 1 exactly when `array_op` is not 0.
- R5: A store or recall request sampled while a transfer runs is discarded. It neither lengthens nor repeats the transfer.
- R6: A store request sampled while `supply_ok` is 0 is ignored, and the block stays idle.
- R7: If `supply_ok` is sampled 0 during a store, the next cycle shows `array_op` = 0 and `busy` = 0, and `store_abort` is 1 for exactly that one cycle.
- R8: A recall runs its full length even while `supply_ok` is 0.
- R9: The first rising edge of `supply_ok` after reset, sampled while idle, starts a recall of RESTORE_CYC cycles (clear, then copy). This takes priority over any request sampled at the same edge.
- R10: Later rising edges of `supply_ok` start nothing, except the first rising edge after a store abort, which starts another restore recall.
- R11: When both requests are sampled while idle, the recall is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| store_req | input | 1 | Request a working-to-shadow transfer |
| recall_req | input | 1 | Request a shadow-to-working transfer |
| supply_ok | input | 1 | Supply is above the operating threshold |
| busy | output | 1 | A transfer is in progress |
| bus_off | output | 1 | Bus inputs ignored, data outputs to be held high-impedance |
| array_op | output | 3 | Phase code: 0 idle, 1 erase, 2 program, 3 clear, 4 copy |
| store_abort | output | 1 | One-cycle pulse when a store is cut short by low supply |

## Verification
Every output is registered, so all results are due one clock after the edge that samples the stimulus. A request, or a change of `supply_ok`, is driven after a falling edge and sampled at the next rising edge. Its effect is read at the falling edge after that. Phase changes then follow at fixed cycle counts from that first edge, and the abort pulse appears in the cycle right after low supply is sampled. A behavioural model in the bench keeps a count of the remaining cycles. It updates at the same rising edges, and its predictions are compared with the outputs at every falling edge. Directed checks at the computed cycles are added for each scenario.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

  // Phase codes shown to the array; the controller state uses the same encoding.
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_ERASE = 3'd1,
    OP_PROG  = 3'd2,
    OP_CLEAR = 3'd3,
    OP_COPY  = 3'd4
  } xfer_op_e;

endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/nv_supply_watch.sv
module nv_supply_watch (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic rearm,
  input  logic consume,
  output logic auto_go
);

  logic ok_q;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q  <= 1'b0;
      armed <= 1'b1;
    end else begin
      ok_q <= supply_ok;
      if (rearm)        armed <= 1'b1;
      else if (consume) armed <= 1'b0;
    end
  end

  assign auto_go = supply_ok & ~ok_q & armed;

  // R10: an automatic recall is consumed only once per arming
  a_r10_consume_disarms: assert property (@(posedge clk) disable iff (rst)
    consume |=> !auto_go);

endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nv_xfer_pkg::*;
#(
  // Totals in clock cycles; each must be at least 2.
  parameter int STORE_CYC   = 2500000,
  parameter int RECALL_CYC  = 5000,
  parameter int RESTORE_CYC = 162500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       store_req,
  input  logic       recall_req,
  input  logic       supply_ok,
  output logic       busy,
  output logic       bus_off,
  output logic [2:0] array_op,
  output logic       store_abort
);

  localparam int MAX_A = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAXC  = (MAX_A > RESTORE_CYC) ? MAX_A : RESTORE_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  localparam int ST_P1 = STORE_CYC / 2;
  localparam int ST_P2 = STORE_CYC - ST_P1;
  localparam int RC_P1 = RECALL_CYC / 2;
  localparam int RC_P2 = RECALL_CYC - RC_P1;
  localparam int RS_P1 = RESTORE_CYC / 2;
  localparam int RS_P2 = RESTORE_CYC - RS_P1;

  xfer_op_e      st, nxt;
  logic [CW-1:0] p2_len, p2_nxt;
  logic [CW-1:0] ld_val;
  logic          ld, t_zero;
  logic          abort_n, rearm, consume, auto_go;

  nv_phase_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .zero(t_zero)
  );

  nv_supply_watch i_watch (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .rearm(rearm), .consume(consume), .auto_go(auto_go)
  );

  always_comb begin
    nxt     = st;
    ld      = 1'b0;
    ld_val  = '0;
    p2_nxt  = p2_len;
    abort_n = 1'b0;
    rearm   = 1'b0;
    consume = 1'b0;
    case (st)
      OP_IDLE: begin
        if (auto_go) begin
          nxt = OP_CLEAR; ld = 1'b1; consume = 1'b1;
          ld_val = CW'(RS_P1 - 1); p2_nxt = CW'(RS_P2 - 1);
        end else if (recall_req) begin
          nxt = OP_CLEAR; ld = 1'b1;
          ld_val = CW'(RC_P1 - 1); p2_nxt = CW'(RC_P2 - 1);
        end else if (store_req && supply_ok) begin
          nxt = OP_ERASE; ld = 1'b1;
          ld_val = CW'(ST_P1 - 1);
        end
      end
      OP_ERASE: begin
        if (!supply_ok) begin
          nxt = OP_IDLE; abort_n = 1'b1; rearm = 1'b1;
        end else if (t_zero) begin
          nxt = OP_PROG; ld = 1'b1; ld_val = CW'(ST_P2 - 1);
        end
      end
      OP_PROG: begin
        if (!supply_ok) begin
          nxt = OP_IDLE; abort_n = 1'b1; rearm = 1'b1;
        end else if (t_zero) begin
          nxt = OP_IDLE;
        end
      end
      OP_CLEAR: begin
        if (t_zero) begin
          nxt = OP_COPY; ld = 1'b1; ld_val = p2_len;
        end
      end
      OP_COPY: begin
        if (t_zero) nxt = OP_IDLE;
      end
      default: nxt = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= OP_IDLE;
      p2_len      <= '0;
      busy        <= 1'b0;
      bus_off     <= 1'b0;
      store_abort <= 1'b0;
    end else begin
      st          <= nxt;
      p2_len      <= p2_nxt;
      busy        <= (nxt != OP_IDLE);
      bus_off     <= (nxt != OP_IDLE);
      store_abort <= abort_n;
    end
  end

  assign array_op = st;

  a_r4_flags_follow_op: assert property (@(posedge clk) disable iff (rst)
    (busy == bus_off) && (busy == (array_op != 3'd0)));

  a_r7_abort_one_cycle: assert property (@(posedge clk) disable iff (rst)
    store_abort |=> !store_abort);

  a_r7_abort_cause: assert property (@(posedge clk) disable iff (rst)
    store_abort |-> (!$past(supply_ok) &&
                     ($past(array_op) == 3'd1 || $past(array_op) == 3'd2)));

  a_r6_store_needs_supply: assert property (@(posedge clk) disable iff (rst)
    (array_op == 3'd1 && $past(array_op) == 3'd0) |-> $past(supply_ok));

  a_r2_erase_then_program: assert property (@(posedge clk) disable iff (rst)
    (array_op == 3'd1) |=> (array_op == 3'd1 || array_op == 3'd2 || store_abort));

  a_r8_recall_continues: assert property (@(posedge clk) disable iff (rst)
    (array_op == 3'd3) |=> (array_op == 3'd3 || array_op == 3'd4));

endmodule

// File: tb/test_nv_xfer_ctrl.sv
`timescale 1ns/1ps
module test_nv_xfer_ctrl;

  localparam int ST = 20;
  localparam int RC = 11;
  localparam int RS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic store_req = 1'b0, recall_req = 1'b0, supply_ok = 1'b0;
  logic busy, bus_off, store_abort;
  logic [2:0] array_op;

  int n_run = 0, n_fail = 0, cyc_cnt = 0;
  string tag = "R1";
  bit live = 1'b0;

  always #2 clk = ~clk;

  nv_xfer_ctrl #(.STORE_CYC(ST), .RECALL_CYC(RC), .RESTORE_CYC(RS)) i_nv_xfer_ctrl (
    .clk(clk), .rst(rst), .store_req(store_req), .recall_req(recall_req),
    .supply_ok(supply_ok), .busy(busy), .bus_off(bus_off),
    .array_op(array_op), .store_abort(store_abort)
  );

  // Behavioural reference: remaining-cycle count per transfer
  int m_left = 0, m_len = 0;
  bit m_store = 0, m_armed = 1, m_okq = 0, m_abort = 0;

  always @(posedge clk) begin
    bit rise;
    if (rst) begin
      m_left = 0; m_len = 0; m_store = 0; m_armed = 1; m_okq = 0; m_abort = 0;
    end else begin
      rise = supply_ok && !m_okq;
      m_okq = supply_ok;
      m_abort = 0;
      if (m_left == 0) begin
        if (m_armed && rise) begin
          m_len = RS; m_left = RS; m_store = 0; m_armed = 0;
        end else if (recall_req) begin
          m_len = RC; m_left = RC; m_store = 0;
        end else if (store_req && supply_ok) begin
          m_len = ST; m_left = ST; m_store = 1;
        end
      end else if (m_store && !supply_ok) begin
        m_left = 0; m_abort = 1; m_armed = 1;
      end else begin
        m_left = m_left - 1;
      end
    end
  end

  function automatic int exp_op();
    bit first;
    if (m_left == 0) return 0;
    first = (m_len - m_left) < (m_len / 2);
    if (m_store) return first ? 1 : 2;
    return first ? 3 : 4;
  endfunction

  always @(negedge clk) begin
    if (live) begin
      n_run++;
      if (array_op != 3'(exp_op()) || busy != (m_left != 0) || store_abort != m_abort) begin
        n_fail++;
        $display("FAIL %s model: op=%0d busy=%0d abort=%0d expected op=%0d busy=%0d abort=%0d",
                 tag, array_op, busy, store_abort, exp_op(), (m_left != 0), m_abort);
      end
      n_run++;
      if (bus_off != busy || busy != (array_op != 3'd0)) begin
        n_fail++;
        $display("FAIL R4 busy=%0d bus_off=%0d op=%0d expected busy=bus_off=%0d",
                 busy, bus_off, array_op, (array_op != 3'd0));
      end
    end
  end

  task automatic expect_eq(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    live = 1'b1;
    expect_eq("R1 op", array_op, 0);
    expect_eq("R1 busy", busy, 0);
    expect_eq("R1 abort", store_abort, 0);

    // R9: first supply rise beats a simultaneous recall request
    tag = "R9";
    supply_ok = 1'b1; recall_req = 1'b1;
    cyc(1); recall_req = 1'b0;
    expect_eq("R9 clear", array_op, 3);
    cyc(3);
    tag = "R5";
    store_req = 1'b1; cyc(1); store_req = 1'b0;
    cyc(RS - 4);
    expect_eq("R9 restore length", busy, 0);
    cyc(2);

    // R2 store phases, R5 recall dropped during program
    tag = "R2";
    store_req = 1'b1; cyc(1); store_req = 1'b0;
    expect_eq("R2 erase", array_op, 1);
    cyc(ST / 2);
    expect_eq("R2 program", array_op, 2);
    tag = "R5";
    recall_req = 1'b1; cyc(1); recall_req = 1'b0;
    cyc(ST / 2 - 1);
    expect_eq("R5 no recall after store", array_op, 0);
    cyc(2);

    // R3 recall phases
    tag = "R3";
    recall_req = 1'b1; cyc(1); recall_req = 1'b0;
    expect_eq("R3 clear", array_op, 3);
    cyc(RC / 2);
    expect_eq("R3 copy", array_op, 4);
    cyc(RC - RC / 2);
    expect_eq("R3 done", array_op, 0);
    cyc(2);

    // R11 both requests together
    tag = "R11";
    recall_req = 1'b1; store_req = 1'b1; cyc(1);
    recall_req = 1'b0; store_req = 1'b0;
    expect_eq("R11 recall wins", array_op, 3);
    cyc(RC + 2);

    // R6 store inhibited on low supply
    tag = "R6";
    supply_ok = 1'b0; cyc(2);
    store_req = 1'b1; cyc(1); store_req = 1'b0;
    expect_eq("R6 stays idle", busy, 0);
    cyc(2);

    // R8 recall runs with low supply
    tag = "R8";
    recall_req = 1'b1; cyc(1); recall_req = 1'b0;
    expect_eq("R8 clear", array_op, 3);
    cyc(RC - 1);
    expect_eq("R8 still copying", array_op, 4);
    cyc(1);
    expect_eq("R8 done", busy, 0);

    // R10 later rise without abort starts nothing
    tag = "R10";
    supply_ok = 1'b1; cyc(3);
    expect_eq("R10 no auto recall", busy, 0);

    // R7 store abort on low supply
    tag = "R7";
    store_req = 1'b1; cyc(1); store_req = 1'b0;
    cyc(5);
    supply_ok = 1'b0; cyc(1);
    expect_eq("R7 busy drops", busy, 0);
    expect_eq("R7 abort pulse", store_abort, 1);
    cyc(1);
    expect_eq("R7 pulse one cycle", store_abort, 0);

    // R10 rise after abort re-runs the restore recall
    tag = "R10";
    cyc(2);
    supply_ok = 1'b1; cyc(1);
    expect_eq("R10 auto recall rearmed", array_op, 3);
    cyc(RS + 3);
    expect_eq("R10 idle after restore", busy, 0);

    live = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule